// File: doc/BRIEF.md
# Soft-Start and Hiccup Protection Sequencer

This block sequences the start-up and fault handling of a two-phase buck regulator. It models the soft-start capacitor as a 12-bit up/down counter, where 4095 stands for 5 V. The counter steps by one count every `PRESC` clock cycles, and the step size is the same when charging and when discharging. Three things depend on that counter level: whether the gate drivers may switch, whether phase-current sensing runs, and whether power-good is reported. The same counter also serves as the timer for over-current and under-voltage hiccup.

The analog comparators sit outside the block and deliver synchronous flags:
- power-on-reset release;
- an external pull-down on the soft-start line;
- over-current from either phase;
- feedback under-voltage;
- over-temperature.

Two thresholds are used, each computed as `floor(k*4095/50)`:
- The high threshold (3.7 V) is 3030.
- The low threshold (0.4 V) is 327.

A third over-current event latches a shutdown. Only a power-on reset clears it.

Top module: `ss_hiccup_seq`

## Requirements
- R1: While `por_rel` is low, the next sampled `ss_level` is 0 and `gate_en`, `sense_en` and `pgood` are low. The over-current tally is cleared.
- R2: After `por_rel` rises, `ss_level` counts up by one every `PRESC` cycles, starting from 0.
- R3: During start-up, `gate_en` and `sense_en` are high exactly when `ss_level` is at least 327.
- R4: When `ss_level` reaches 3030 with no fault flag, `pgood` rises. `pgood` is never high while `ss_level` is below 3030.
- R5: `oc_flag` and `uv_flag` have no effect while `ss_level` is below 3030 during start-up. They neither delay `pgood` nor count toward shutdown.
- R6: If `oc_flag` is high while `pgood` is high, then in the next cycle `gate_en`, `sense_en` and `pgood` are low. `ss_level` then falls by one every `PRESC` cycles.
- R7: When the falling level reaches 327, charging resumes and `gate_en` rises within a few counts of 327. `pgood` returns once the level reaches 3030 again.
- R8: While `ss_pull` is high, `ss_level` is 0 from the next cycle and `gate_en` is low. After release, the ramp restarts from 0.
- R9: The third counted over-current event since power-on reset latches shutdown. In shutdown, `ss_level` is 0 and all outputs are low until `por_rel` goes low.
- R10: `uv_flag` high while `pgood` is high starts a continuous hiccup. The level falls to 327, rises to 3030, and falls again, with no further flag. `pgood` stays low throughout, and gates are enabled only while the level is charging above 327.
- R11: `ot_flag` high causes a latched shutdown. `gate_en` and `pgood` are low from the next cycle.
- R12: `sense_en` is low whenever a fault is present: over-current discharge, under-voltage hiccup, or shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_rel | input | 1 | Power-on reset released (1 = supply good) |
| ss_pull | input | 1 | External pull-down on the soft-start line |
| oc_flag | input | 1 | Over-current seen on either phase this cycle |
| uv_flag | input | 1 | Feedback below the 0.6 V equivalent |
| ot_flag | input | 1 | Over-temperature |
| ss_level | output | LVL_W | Soft-start level (4095 = 5 V) |
| gate_en | output | 1 | PWM allowed to reach both phases' gates |
| sense_en | output | 1 | Phase-current sensing enabled |
| pgood | output | 1 | Power good |

## Verification
The hardest state to reach is the latched shutdown after the third over-current. Over-current events during start-up must not be counted, so the stimulus mixes random over-current and under-voltage pulses into the first ramp. It then needs exactly three events at full level, separated by complete discharge and recharge cycles and interrupted by a pull-down that must not clear the tally. Only then is the latch observed. The under-voltage hiccup also needs a full fall-rise-fall cycle with the flag already cleared, to show that the hiccup does not stop by itself.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_RAMP,
        ST_RUN,
        ST_OCDN,
        ST_UVDN,
        ST_UVUP,
        ST_SHUT
    } seq_st_e;

    typedef enum logic [1:0] {
        LV_HOLD,
        LV_UP,
        LV_DOWN,
        LV_ZERO
    } lvl_cmd_e;
endpackage

// File: rtl/ss_tick_gen.sv
module ss_tick_gen #(
    parameter int PRESC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ss_level_ctr.sv
module ss_level_ctr
    import ss_seq_pkg::*;
#(
    parameter int LVL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  lvl_cmd_e         cmd,
    output logic [LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0] lvl_nxt
);
    localparam logic [LVL_W-1:0] TOP = '1;

    always_comb begin
        lvl_nxt = lvl_q;
        case (cmd)
            LV_ZERO: lvl_nxt = '0;
            LV_UP:   if (tick && lvl_q != TOP) lvl_nxt = lvl_q + 1'b1;
            LV_DOWN: if (tick && lvl_q != '0)  lvl_nxt = lvl_q - 1'b1;
            default: lvl_nxt = lvl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_nxt;
    end
endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq
    import ss_seq_pkg::*;
#(
    parameter int LVL_W    = 12,
    parameter int PRESC    = 4,
    parameter int OC_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_rel,
    input  logic             ss_pull,
    input  logic             oc_flag,
    input  logic             uv_flag,
    input  logic             ot_flag,
    output logic [LVL_W-1:0] ss_level,
    output logic             gate_en,
    output logic             sense_en,
    output logic             pgood
);
    localparam int FULL  = (1 << LVL_W) - 1;
    localparam int TH_HI = (37 * FULL) / 50;
    localparam int TH_LO = (4 * FULL) / 50;
    localparam int CNT_W = $clog2(OC_LIMIT + 1);
    localparam logic [LVL_W-1:0] HI_L = LVL_W'(TH_HI);
    localparam logic [LVL_W-1:0] LO_L = LVL_W'(TH_LO);
    localparam logic [CNT_W-1:0] LAST_OC = CNT_W'(OC_LIMIT - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] oc_cnt;
        logic             gate;
        logic             sense;
        logic             pg;
    } seq_reg_t;

    seq_reg_t         cur_q, nxt_d;
    lvl_cmd_e         cmd_d;
    logic             tick;
    logic [LVL_W-1:0] lvl_q, lvl_nxt;
    logic             hi_q, lo_q, chg_d;

    ss_tick_gen #(.PRESC(PRESC)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ss_level_ctr #(.LVL_W(LVL_W)) lvl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmd     (cmd_d),
        .lvl_q   (lvl_q),
        .lvl_nxt (lvl_nxt)
    );

    assign hi_q = (lvl_q >= HI_L);
    assign lo_q = (lvl_q <= LO_L);

    always_comb begin
        nxt_d = cur_q;

        // level command from present state
        case (cur_q.st)
            ST_RAMP, ST_RUN, ST_UVUP: cmd_d = LV_UP;
            ST_OCDN, ST_UVDN:         cmd_d = LV_DOWN;
            default:                  cmd_d = LV_ZERO;
        endcase
        if (ss_pull || !por_rel) cmd_d = LV_ZERO;

        // state sequencing
        if (!por_rel) begin
            nxt_d.st     = ST_OFF;
            nxt_d.oc_cnt = '0;
        end else if (cur_q.st == ST_OFF) begin
            nxt_d.st = ST_RAMP;
        end else if (ot_flag) begin
            nxt_d.st = ST_SHUT;
        end else begin
            case (cur_q.st)
                ST_RAMP, ST_RUN: begin
                    if (ss_pull) begin
                        nxt_d.st = ST_RAMP;
                    end else if (hi_q) begin
                        if (oc_flag) begin
                            nxt_d.oc_cnt = cur_q.oc_cnt + 1'b1;
                            nxt_d.st = (cur_q.oc_cnt >= LAST_OC) ? ST_SHUT : ST_OCDN;
                        end else if (uv_flag) begin
                            nxt_d.st = ST_UVDN;
                        end else begin
                            nxt_d.st = ST_RUN;
                        end
                    end
                end
                ST_OCDN: if (lo_q) nxt_d.st = ST_RAMP;
                ST_UVDN: if (lo_q) nxt_d.st = ST_UVUP;
                ST_UVUP: if (hi_q) nxt_d.st = ST_UVDN;
                default: nxt_d.st = cur_q.st;
            endcase
        end

        // outputs follow the next state and next level
        chg_d       = (nxt_d.st == ST_RAMP) || (nxt_d.st == ST_RUN) || (nxt_d.st == ST_UVUP);
        nxt_d.gate  = chg_d && (lvl_nxt >= LO_L);
        nxt_d.sense = ((nxt_d.st == ST_RAMP) || (nxt_d.st == ST_RUN)) && (lvl_nxt >= LO_L);
        nxt_d.pg    = (nxt_d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_OFF, oc_cnt: '0, gate: 1'b0, sense: 1'b0, pg: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign ss_level = lvl_q;
    assign gate_en  = cur_q.gate;
    assign sense_en = cur_q.sense;
    assign pgood    = cur_q.pg;

    // R1
    por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_rel |=> (ss_level == '0) && !gate_en && !pgood);

    // R4
    pg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (ss_level >= HI_L));

    // R6
    oc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && oc_flag) |=> (!gate_en && !pgood && !sense_en));

    // R8
    pull_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_pull |=> (!gate_en && ss_level == '0));

    // R9
    shut_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_SHUT && por_rel) |=> (cur_q.st == ST_SHUT));

    // R11
    ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> (!gate_en && !pgood));
endmodule

// File: tb/ss_hiccup_seq_tb_top.sv
`timescale 1ns/1ps
module ss_hiccup_seq_tb_top;
    localparam int PR = 2;
    localparam int HI = 3030;
    localparam int LO = 327;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, por_rel, ss_pull, oc_flag, uv_flag, ot_flag;
    logic [11:0] ss_level;
    logic gate_en, sense_en, pgood;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    ss_hiccup_seq #(.LVL_W(12), .PRESC(PR), .OC_LIMIT(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_rel(por_rel), .ss_pull(ss_pull),
        .oc_flag(oc_flag), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .ss_level(ss_level), .gate_en(gate_en), .sense_en(sense_en), .pgood(pgood)
    );

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic int ramp_cycles(input int from, input int to);
        return (to - from) * PR;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_level(input bit rise, input int thr, input int maxc,
                              output int cyc, output int pg_hi, output int sn_hi, output int gt_hi);
        cyc = 0; pg_hi = 0; sn_hi = 0; gt_hi = 0;
        while (cyc < maxc && (rise ? (int'(ss_level) < thr) : (int'(ss_level) > thr))) begin
            @(negedge clk);
            cyc++;
            if (pgood) pg_hi++;
            if (sense_en) sn_hi++;
            if (gate_en) gt_hi++;
        end
    endtask

    task automatic wait_pg(input int maxc, output int cyc);
        cyc = 0;
        while (!pgood && cyc < maxc) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_gate(input int maxc, output int cyc);
        cyc = 0;
        while (!gate_en && cyc < maxc) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic pulse_oc();
        oc_flag = 1'b1;
        @(negedge clk);
        oc_flag = 1'b0;
    endtask

    task automatic por_cycle();
        por_rel = 1'b0;
        step(5);
        chk(ss_level == 0 && !gate_en && !pgood && !sense_en, "R1 por low", int'(ss_level), 0);
        por_rel = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c, pgh, snh, gth, lvl, mism, seed;
        seed = $urandom(32'h5eed);
        rst_n = 0; por_rel = 0; ss_pull = 0; oc_flag = 0; uv_flag = 0; ot_flag = 0;
        step(5);
        rst_n = 1;
        step(5);

        // R1 reset / POR-held state
        chk(ss_level == 0 && !gate_en && !sense_en && !pgood, "R1 reset", int'(ss_level), 0);

        // R2 linear ramp
        por_rel = 1'b1;
        step(200);
        chk(absd(int'(ss_level), 200 / PR) <= 3, "R2 ramp rate", int'(ss_level), 200 / PR);
        chk(!gate_en && !sense_en, "R3 gates off below low threshold", int'(gate_en), 0);

        // R5 random over-current / under-voltage noise during start-up; R3 per cycle
        mism = 0;
        c = 200;
        while (int'(ss_level) < HI - 60) begin
            oc_flag = ($urandom % 8) == 0;
            uv_flag = ($urandom % 8) == 0;
            @(negedge clk);
            c++;
            if (gate_en != (int'(ss_level) >= LO)) mism++;
            if (sense_en != (int'(ss_level) >= LO)) mism++;
        end
        oc_flag = 0; uv_flag = 0;
        chk(mism == 0, "R3 gate/sense follow low threshold", mism, 0);

        // R4 power-good at high threshold
        wait_pg(2000, pgh);
        c = c + pgh + 1;
        chk(pgood == 1'b1, "R5 noise ignored, pgood reached", int'(pgood), 1);
        chk(absd(c, ramp_cycles(0, HI)) <= 8, "R4 pgood timing", c, ramp_cycles(0, HI));
        chk(int'(ss_level) >= HI && int'(ss_level) <= HI + 2, "R4 pgood level", int'(ss_level), HI);

        // OC 1: R6, R12, R7
        step(20);
        pulse_oc();
        chk(!gate_en && !pgood, "R6 oc cuts gates and pgood", int'(gate_en), 0);
        chk(!sense_en, "R12 sense off in oc discharge", int'(sense_en), 0);
        lvl = int'(ss_level);
        step(40);
        chk(absd(int'(ss_level), lvl - 40 / PR) <= 2, "R6 discharge rate", int'(ss_level), lvl - 40 / PR);
        wait_gate(10000, c);
        chk(absd(int'(ss_level), LO) <= 3, "R7 recharge at low threshold", int'(ss_level), LO);
        wait_pg(10000, c);
        chk(pgood == 1'b1, "R7 pgood returns", int'(pgood), 1);

        // OC 2
        step(10);
        pulse_oc();
        chk(!gate_en && !pgood, "R6 second oc", int'(gate_en), 0);
        wait_pg(20000, c);
        chk(pgood == 1'b1, "R7 pgood after second oc", int'(pgood), 1);

        // R8 external pull-down
        ss_pull = 1'b1;
        step(10);
        chk(ss_level == 0 && !gate_en && !pgood, "R8 pull forces zero", int'(ss_level), 0);
        ss_pull = 1'b0;
        step(100);
        chk(absd(int'(ss_level), 100 / PR) <= 3, "R8 ramp restarts", int'(ss_level), 100 / PR);
        wait_pg(10000, c);
        chk(pgood == 1'b1, "R8 pgood after pull", int'(pgood), 1);

        // R9 third over-current latches shutdown
        step(10);
        pulse_oc();
        chk(!gate_en && !pgood, "R9 third oc off", int'(gate_en), 0);
        for (int i = 0; i < 2000; i++) begin
            uv_flag = (i % 97) == 0;
            oc_flag = (i % 131) == 0;
            @(negedge clk);
        end
        uv_flag = 0; oc_flag = 0;
        step(2);
        chk(ss_level == 0 && !gate_en && !pgood && !sense_en, "R9 shutdown latched", int'(ss_level), 0);
        por_cycle();
        wait_pg(10000, c);
        chk(pgood == 1'b1, "R9 por clears shutdown", int'(pgood), 1);

        // R10 under-voltage continuous hiccup
        step(10);
        uv_flag = 1'b1;
        @(negedge clk);
        uv_flag = 1'b0;
        chk(!gate_en && !pgood && !sense_en, "R10 uv cuts outputs", int'(pgood), 0);
        wait_level(1'b0, LO, 20000, c, pgh, snh, gth);
        chk(pgh == 0 && snh == 0 && gth == 0, "R12 uv discharge all off", pgh + snh + gth, 0);
        wait_gate(20, c);
        chk(gate_en == 1'b1, "R10 gates on while charging", int'(gate_en), 1);
        wait_level(1'b1, HI, 20000, c, pgh, snh, gth);
        chk(pgh == 0 && snh == 0, "R10 no pgood/sense in hiccup", pgh + snh, 0);
        chk(absd(c, ramp_cycles(LO, HI)) <= 8, "R10 hiccup charge time", c, ramp_cycles(LO, HI));
        step(40);
        chk(int'(ss_level) < HI && !gate_en && !pgood, "R10 hiccup repeats", int'(ss_level), HI - 20);

        // R11 over-temperature
        por_cycle();
        wait_pg(10000, c);
        step(5);
        ot_flag = 1'b1;
        @(negedge clk);
        ot_flag = 1'b0;
        chk(!gate_en && !pgood, "R11 ot shuts down", int'(gate_en), 0);
        step(100);
        chk(ss_level == 0 && !gate_en && !sense_en, "R11 ot latched", int'(ss_level), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule